// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines and hands the processor one at a time. It masks each line on its own, ranks the surviving requests under one of two schemes, and raises a single interrupt output when a request outranks everything already being serviced. When the processor acknowledges, the winning line is recorded as in service. In the next cycle an 8-bit vector appears on the vector bus, built from a software base value and the line number.

Software programs the block through a four-word write port. The words hold the mask, the priority scheme (fixed nested or rotating), the vector base, and an end-of-interrupt command that retires the highest-ranked in-service line. One request line can be set aside for a second controller of the same kind. When that line wins, the acknowledge is passed on to the second controller, and the vector it supplies is forwarded in place of the local one. With the second controller on line 2, the pair gives fifteen usable requests.

Top module: `pic_ctrl`

## Requirements
- R1: After synchronous reset all eight lines are masked, the scheme is fixed nested, the vector base is zero, nothing is in service, and `int_o`, `vec_oe_o` and `slv_inta_o` are low.
- R2: A write to address 0 loads the mask, where bit i set to 1 blocks line i. A masked line never causes `int_o` to rise, whatever its request level.
- R3: Request lines are sampled into a register one cycle before they are evaluated. In nested mode (address 1, bit 0 = 0) line 0 ranks highest and line 7 lowest. `int_o` is high exactly while some unmasked pending line outranks every in-service line, or while such a line is pending and nothing is in service.
- R4: An acknowledge is `inta_i` sampled high on a clock edge while `int_o` is high. It places the highest-ranked unmasked pending line in service. In the following cycle `vec_oe_o` is high with the vector on `vec_o`.
- R5: A pending request that ranks equal to or below the highest in-service line keeps `int_o` low. A request that ranks above it raises `int_o`, so servicing can nest.
- R6: Any write to address 3 is an end-of-interrupt. It removes the highest-ranked line from the in-service set.
- R7: In rotating mode (address 1, bit 0 = 1), an end-of-interrupt makes the retired line the lowest rank. Rank then rises from the line just after it, wrapping from 7 to 0. Before any rotation, line 0 ranks highest.
- R8: A write to address 2 sets the vector base from data bits 7:3. A local vector carries the base in bits 7:3 and the line number in bits 2:0.
- R9: An acknowledge of the cascade line (line 2) raises `slv_inta_o` in the same cycle as `inta_i`. In the following cycle `vec_o` carries `slv_vec_i`. An acknowledge of any other line leaves `slv_inta_o` low.
- R10: `inta_i` sampled while `int_o` is low is ignored. No vector is issued, and the in-service set does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 8 | Interrupt request lines, active high |
| int_o | output | 1 | Interrupt to the processor |
| inta_i | input | 1 | Processor acknowledge, one-cycle pulse |
| vec_o | output | 8 | Vector bus |
| vec_oe_o | output | 1 | Vector bus drive enable |
| slv_inta_o | output | 1 | Acknowledge forwarded to the cascaded controller |
| slv_vec_i | input | 8 | Vector from the cascaded controller |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 mask, 1 scheme, 2 base, 3 end-of-interrupt |
| cfg_wdata | input | 8 | Register write data |

## Verification
The bench builds the controller with cascading enabled and the cascade on line 2. This makes the vector hand-over and the forwarded acknowledge observable at the ports, next to ordinary local vectors from the other seven lines. Directed phases walk through masking, nesting, end-of-interrupt order and several rotations of the round-robin pointer. A long stretch of mixed random requests, acknowledges and register writes then exercises switches between the two schemes while lines are in service.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int LINES  = 8;
    localparam int LINE_W = $clog2(LINES);
    localparam int VEC_W  = 8;
    localparam int BASE_W = VEC_W - LINE_W;

    typedef enum logic {
        PRI_NESTED = 1'b0,
        PRI_ROTATE = 1'b1
    } pri_mode_e;

    typedef enum logic [1:0] {
        CFG_MASK = 2'd0,
        CFG_MODE = 2'd1,
        CFG_BASE = 2'd2,
        CFG_EOI  = 2'd3
    } cfg_addr_e;

    typedef struct packed {
        logic              hit;
        logic [LINE_W-1:0] idx;
    } pick_t;

    // rotate right so that bit s lands at position 0
    function automatic logic [LINES-1:0] rot_r(input logic [LINES-1:0] v,
                                               input logic [LINE_W-1:0] s);
        logic [2*LINES-1:0] d;
        d = {v, v} >> s;
        return d[LINES-1:0];
    endfunction

    // lowest set position wins
    function automatic pick_t first_set(input logic [LINES-1:0] v);
        pick_t p;
        p.hit = 1'b0;
        p.idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = LINE_W'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [VEC_W-1:0]  wdata,
    output logic [LINES-1:0]  mask_q,
    output pri_mode_e         mode_q,
    output logic [BASE_W-1:0] base_q,
    output logic              eoi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            mode_q <= PRI_NESTED;
            base_q <= '0;
        end else if (we) begin
            case (cfg_addr_e'(addr))
                CFG_MASK: mask_q <= wdata[LINES-1:0];
                CFG_MODE: mode_q <= pri_mode_e'(wdata[0]);
                CFG_BASE: base_q <= wdata[VEC_W-1:LINE_W];
                default:  ;
            endcase
        end
    end

    assign eoi = we && (cfg_addr_e'(addr) == CFG_EOI);

endmodule

// File: rtl/pic_resolve.sv
module pic_resolve
    import pic_pkg::*;
(
    input  logic [LINES-1:0]  req,
    input  logic [LINES-1:0]  mask,
    input  logic [LINES-1:0]  isr,
    input  pri_mode_e         mode,
    input  logic [LINE_W-1:0] lo,
    output pick_t             win,
    output pick_t             top,
    output logic              eligible
);

    logic [LINE_W-1:0] start;
    pick_t             pr;
    pick_t             pt;

    always_comb begin
        start    = (mode == PRI_ROTATE) ? LINE_W'(lo + 1'b1) : '0;
        pr       = first_set(rot_r(req & ~mask, start));
        pt       = first_set(rot_r(isr, start));
        win.hit  = pr.hit;
        win.idx  = LINE_W'(pr.idx + start);
        top.hit  = pt.hit;
        top.idx  = LINE_W'(pt.idx + start);
        // ranks are the rotated positions: smaller is stronger
        eligible = pr.hit && (!pt.hit || (pr.idx < pt.idx));
    end

endmodule

// File: rtl/pic_service.sv
module pic_service
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ack,
    input  pick_t             win,
    input  pick_t             top,
    input  logic              eoi,
    input  pri_mode_e         mode,
    input  logic [BASE_W-1:0] base,
    input  logic              casc_hit,
    output logic [LINES-1:0]  isr_q,
    output logic [LINE_W-1:0] lo_q,
    output logic [VEC_W-1:0]  vec_q,
    output logic              vec_oe_q,
    output logic              casc_q
);

    logic [LINES-1:0] set_v;
    logic [LINES-1:0] clr_v;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign set_v[g] = ack && (win.idx == LINE_W'(g));
        assign clr_v[g] = eoi && top.hit && (top.idx == LINE_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q    <= '0;
            lo_q     <= '1;
            vec_q    <= '0;
            vec_oe_q <= 1'b0;
            casc_q   <= 1'b0;
        end else begin
            isr_q    <= (isr_q | set_v) & ~clr_v;
            vec_oe_q <= ack;
            if (eoi && top.hit && mode == PRI_ROTATE)
                lo_q <= top.idx;
            if (ack) begin
                vec_q  <= {base, win.idx};
                casc_q <= casc_hit;
            end
        end
    end

    p_ack_marks_r4: assert property (@(posedge clk) disable iff (rst)
        ack |=> (vec_oe_q && isr_q[$past(win.idx)]));

    p_eoi_one_r6: assert property (@(posedge clk) disable iff (rst)
        (eoi && top.hit && !ack) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

    p_rot_lowest_r7: assert property (@(posedge clk) disable iff (rst)
        (eoi && top.hit && mode == PRI_ROTATE) |=> (lo_q == $past(top.idx)));

endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter bit          CASC_EN   = 1'b1,
    parameter int unsigned CASC_LINE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] irq_i,
    output logic             int_o,
    input  logic             inta_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_oe_o,
    output logic             slv_inta_o,
    input  logic [VEC_W-1:0] slv_vec_i,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [VEC_W-1:0] cfg_wdata
);

    localparam logic [LINE_W-1:0] CASC_IDX = LINE_W'(CASC_LINE);

    logic [LINES-1:0]  req_q;
    logic [LINES-1:0]  mask_q;
    pri_mode_e         mode_q;
    logic [BASE_W-1:0] base_q;
    logic              eoi;
    logic [LINES-1:0]  isr_q;
    logic [LINE_W-1:0] lo_q;
    logic [VEC_W-1:0]  vec_q;
    logic              casc_q;
    logic              casc_hit;
    logic              eligible;
    logic              ack;
    pick_t             win;
    pick_t             top;

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= irq_i;
    end

    pic_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .mask_q (mask_q),
        .mode_q (mode_q),
        .base_q (base_q),
        .eoi    (eoi)
    );

    pic_resolve u_res (
        .req      (req_q),
        .mask     (mask_q),
        .isr      (isr_q),
        .mode     (mode_q),
        .lo       (lo_q),
        .win      (win),
        .top      (top),
        .eligible (eligible)
    );

    assign int_o = eligible;
    assign ack   = inta_i && eligible;

    if (CASC_EN) begin : g_casc
        assign casc_hit   = (win.idx == CASC_IDX);
        assign slv_inta_o = ack && casc_hit;
        assign vec_o      = casc_q ? slv_vec_i : vec_q;
    end else begin : g_solo
        assign casc_hit   = 1'b0;
        assign slv_inta_o = 1'b0;
        assign vec_o      = vec_q;
    end

    pic_service u_svc (
        .clk      (clk),
        .rst      (rst),
        .ack      (ack),
        .win      (win),
        .top      (top),
        .eoi      (eoi),
        .mode     (mode_q),
        .base     (base_q),
        .casc_hit (casc_hit),
        .isr_q    (isr_q),
        .lo_q     (lo_q),
        .vec_q    (vec_q),
        .vec_oe_q (vec_oe_o),
        .casc_q   (casc_q)
    );

    p_masked_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        ((req_q & ~mask_q) == '0) |-> !int_o);

    p_casc_forward_r9: assert property (@(posedge clk) disable iff (rst)
        slv_inta_o |=> (vec_oe_o && vec_o == slv_vec_i));

    p_vec_base_r8: assert property (@(posedge clk) disable iff (rst)
        (vec_oe_o && !casc_q) |-> (vec_o[VEC_W-1:LINE_W] == $past(base_q)));

    p_ack_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (inta_i && !int_o) |=> !vec_oe_o);

endmodule

// File: tb/pic_ctrl_test.sv
module pic_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq;
    logic       inta;
    logic       we;
    logic [1:0] addr;
    logic [7:0] wd;
    logic [7:0] slv_vec;
    logic       int_o;
    logic [7:0] vec_o;
    logic       vec_oe_o;
    logic       slv_inta_o;

    always #4 clk = ~clk;

    pic_ctrl #(.CASC_EN(1'b1), .CASC_LINE(2)) uut (
        .clk        (clk),
        .rst        (rst),
        .irq_i      (irq),
        .int_o      (int_o),
        .inta_i     (inta),
        .vec_o      (vec_o),
        .vec_oe_o   (vec_oe_o),
        .slv_inta_o (slv_inta_o),
        .slv_vec_i  (slv_vec),
        .cfg_we     (we),
        .cfg_addr   (addr),
        .cfg_wdata  (wd)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string tag   = "R1";
    logic [7:0] cur_irq = 8'h00;

    // reference model state
    bit [7:0] m_req, m_mask, m_isr, m_vec;
    bit       m_rot, m_voe, m_casc;
    bit [4:0] m_base;
    int       m_lo;

    function automatic int m_start();
        return m_rot ? (m_lo + 1) % 8 : 0;
    endfunction

    function automatic int m_rank(int l);
        return (l - m_start() + 8) % 8;
    endfunction

    function automatic int m_pick(bit [7:0] v);
        int s = m_start();
        for (int r = 0; r < 8; r++) begin
            int l = (s + r) % 8;
            if (v[l]) return l;
        end
        return -1;
    endfunction

    function automatic bit m_elig();
        int w = m_pick(m_req & ~m_mask);
        int t = m_pick(m_isr);
        if (w < 0) return 1'b0;
        if (t < 0) return 1'b1;
        return m_rank(w) < m_rank(t);
    endfunction

    always @(posedge clk) begin : model
        int       w;
        int       t;
        bit       el;
        bit [7:0] nisr;
        if (rst) begin
            m_req = 0; m_mask = 8'hFF; m_isr = 0; m_vec = 0;
            m_rot = 0; m_voe = 0; m_casc = 0; m_base = 0; m_lo = 7;
        end else begin
            el   = m_elig();
            w    = m_pick(m_req & ~m_mask);
            t    = m_pick(m_isr);
            nisr = m_isr;
            m_voe = inta && el;
            if (inta && el) begin
                nisr[w] = 1'b1;
                m_vec   = {m_base, w[2:0]};
                m_casc  = (w == 2);
            end
            if (we && addr == 2'd3 && t >= 0) begin
                nisr[t] = 1'b0;
                if (m_rot) m_lo = t;
            end
            if (we) begin
                case (addr)
                    2'd0: m_mask = wd;
                    2'd1: m_rot  = wd[0];
                    2'd2: m_base = wd[7:3];
                    default: ;
                endcase
            end
            m_isr = nisr;
            m_req = irq;
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle: compare registered outputs, drive inputs, compare forwarded acknowledge
    task automatic cyc(input logic [7:0] i, input bit a, input bit gate,
                       input bit w, input logic [1:0] ad, input logic [7:0] d);
        bit a_eff;
        @(negedge clk);
        check("int_o", int_o, m_elig());
        check("vec_oe_o", vec_oe_o, m_voe);
        if (m_voe) check("vec_o", vec_o, m_casc ? slv_vec : m_vec);
        a_eff = gate ? (a && int_o) : a;
        irq = i; inta = a_eff; we = w; addr = ad; wd = d;
        #1;
        check("slv_inta_o", slv_inta_o,
              a_eff && m_elig() && (m_pick(m_req & ~m_mask) == 2));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(cur_irq, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic wr(input logic [1:0] ad, input logic [7:0] d);
        cyc(cur_irq, 1'b0, 1'b0, 1'b1, ad, d);
    endtask

    task automatic ack_now();
        cyc(cur_irq, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        rst = 1'b1; irq = 0; inta = 0; we = 0; addr = 0; wd = 0; slv_vec = 8'hA5;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, all lines masked
        tag = "R1";
        idle(2);
        cur_irq = 8'hFF;
        idle(3);

        // R2: mask register
        tag = "R2";
        wr(2'd0, 8'hF7);
        idle(2);
        wr(2'd0, 8'hFF);
        idle(2);
        cur_irq = 8'h00;
        idle(1);

        // R8: vector base
        tag = "R8";
        wr(2'd2, 8'hC8);

        // R3 / R4: nested ranking and acknowledge
        tag = "R3";
        wr(2'd0, 8'h00);
        cur_irq = 8'b0010_1000;
        idle(2);
        tag = "R4";
        ack_now();
        idle(1);

        // R5: nesting
        tag = "R5";
        idle(2);
        cur_irq = cur_irq | 8'h02;
        idle(2);
        ack_now();
        idle(2);

        // R6: end-of-interrupt order
        tag = "R6";
        wr(2'd3, 8'h00);
        idle(2);
        wr(2'd3, 8'h00);
        idle(2);
        ack_now();
        idle(1);
        wr(2'd3, 8'h00);
        cur_irq = 8'h00;
        idle(2);

        // R10: stray acknowledge
        tag = "R10";
        ack_now();
        idle(2);

        // R7: rotation
        tag = "R7";
        wr(2'd1, 8'h01);
        cur_irq = 8'h11;
        idle(2);
        for (int k = 0; k < 4; k++) begin
            ack_now();
            idle(1);
            wr(2'd3, 8'h00);
            idle(1);
        end
        cur_irq = 8'h00;
        wr(2'd1, 8'h00);
        idle(2);

        // R9: cascade forwarding
        tag = "R9";
        slv_vec = 8'h5A;
        cur_irq = 8'h04;
        idle(2);
        ack_now();
        idle(2);
        wr(2'd3, 8'h00);
        cur_irq = 8'h42;
        idle(1);
        ack_now();
        idle(1);
        wr(2'd3, 8'h00);
        cur_irq = 8'h00;
        idle(2);

        // mixed random traffic across all requirements (R3 R5 R7 R9)
        tag = "R3-mix";
        for (int k = 0; k < 4000; k++) begin
            bit         w_en;
            logic [1:0] ad;
            w_en    = ($urandom % 12) == 0;
            ad      = 2'($urandom % 4);
            slv_vec = 8'($urandom);
            cyc(8'($urandom), ($urandom % 3) == 0, 1'b1, w_en, ad,
                (ad == 2'd0) ? 8'($urandom & 32'h0000_0093) : 8'($urandom));
        end
        idle(2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule